// File: doc/BRIEF.md
# Operation Sampling Interval Selector

This block watches a stream of dispatched operations, one valid strobe per cycle, and marks one operation out of every N for profiling. N is a programmable interval counted in operations, not in cycles. Idle cycles do not advance the count. When the programmed interval is zero, a fixed minimum interval set by a parameter takes its place. An optional jitter mode adds a pseudo-random amount to the length of each interval, so that sampling does not lock onto loops with a fixed period.

Only one sampled operation may be tracked at a time. A select pulse sets an in-flight flag, and a completion strobe from the tracked operation clears it. If an interval runs out while the flag is still set, the sample is dropped rather than queued, and a saturating collision counter records the loss. A new interval starts after every expiry, whether the sample was kept or dropped. The counter has a synchronous clear input.

Top module: `op_sample_picker`

## Requirements
- R1: While `rst` is held and in the first cycle after it, `sample_sel` and `inflight` are 0 and `coll_count` is 0.
- R2: With jitter off and a nonzero `interval_cfg` of N, `sample_sel` is 1 in the cycle after the Nth accepted `op_valid` counted from reset or from the previous expiry. Cycles with `op_valid` low do not count and never raise `sample_sel`.
- R3: When `interval_cfg` is 0, the interval is MIN_INTERVAL (8 by default) operations.
- R4: The interval length is taken at the first operation of each interval. With `jitter_en` set, the length is the base interval plus the low 8 bits of a 16-bit LFSR. The LFSR seed after reset is 16'hACE1. It shifts left by one with new bit 0 = bit15 ^ bit13 ^ bit12 ^ bit10, once per interval start. With interval 4, the first two intervals after reset are therefore 229 and 199 operations.
- R5: `inflight` becomes 1 together with `sample_sel`. It returns to 0 in the cycle after a `done_strobe`. A `done_strobe` while `inflight` is 0 has no effect.
- R6: An expiry while `inflight` is 1 and `done_strobe` is low raises no `sample_sel` and adds 1 to `coll_count`. The next interval still starts from the full length.
- R7: An expiry in the same cycle as `done_strobe` is not a collision. `sample_sel` pulses, `inflight` stays 1 and `coll_count` is unchanged.
- R8: `coll_count` saturates at all-ones (CNT_W bits, 32 by default).
- R9: `coll_clear` zeroes `coll_count` at the next edge and takes priority over a collision in the same cycle.
- R10: `sample_sel` is 1 only in a cycle that follows an accepted `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is dispatched this cycle |
| interval_cfg | input | IW | Programmed interval in operations, 0 selects the minimum |
| jitter_en | input | 1 | Add the pseudo-random perturbation to each interval |
| done_strobe | input | 1 | The tracked sampled operation has completed |
| coll_clear | input | 1 | Synchronous clear of the collision counter |
| sample_sel | output | 1 | Registered pulse marking the chosen operation |
| inflight | output | 1 | A sampled operation is being tracked |
| coll_count | output | CNT_W | Saturating count of dropped samples |

## Verification
The hardest state to reach from the ports is a saturated collision counter, because the default 32-bit width cannot be filled in a bench run. The bench therefore instantiates the block with a 4-bit counter. It sets the interval to one and never completes the tracked operation, so every dispatched operation after the first is a collision. Jittered intervals are checked against LFSR steps that the bench computes itself from the stated polynomial and seed. The bench also drives a completion in the exact cycle of an expiry to cover the case where the two meet.

// File: rtl/sample_picker_pkg.sv
package sample_picker_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // x^16 + x^14 + x^13 + x^11 + 1, left-shifting Fibonacci form
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/sp_lfsr.sv
module sp_lfsr
  import sample_picker_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst)         st_q <= LFSR_SEED;
    else if (step_i) st_q <= lfsr_next(st_q);
  end

  assign state_o = st_q;
endmodule

// File: rtl/sp_interval.sv
module sp_interval #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid_i,
  input  logic [CW-1:0] reload_i,
  output logic          fresh_o,
  output logic          expire_o
);
  // cnt_q == 0 means the next operation opens a new interval
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] eff;

  always_comb eff = (cnt_q == '0) ? reload_i : cnt_q;

  assign fresh_o  = op_valid_i && (cnt_q == '0);
  assign expire_o = op_valid_i && (eff == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (op_valid_i) cnt_q <= expire_o ? '0 : eff - CW'(1);
  end
endmodule

// File: rtl/sp_track.sv
module sp_track #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire_i,
  input  logic             done_i,
  input  logic             clear_i,
  output logic             sel_o,
  output logic             inflight_o,
  output logic [CNT_W-1:0] coll_o
);
  logic             sel_q, busy_q;
  logic [CNT_W-1:0] coll_q;
  logic             take, drop;

  assign take = expire_i && (!busy_q || done_i);
  assign drop = expire_i && busy_q && !done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      busy_q <= 1'b0;
      coll_q <= '0;
    end else begin
      sel_q <= take;
      if (take)        busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
      if (clear_i)                   coll_q <= '0;
      else if (drop && !(&coll_q))   coll_q <= coll_q + CNT_W'(1);
    end
  end

  assign sel_o      = sel_q;
  assign inflight_o = busy_q;
  assign coll_o     = coll_q;
endmodule

// File: rtl/op_sample_picker.sv
module op_sample_picker
  import sample_picker_pkg::*;
#(
  parameter int IW           = 16,
  parameter int JIT_W        = 8,
  parameter int MIN_INTERVAL = 8,
  parameter int CNT_W        = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [IW-1:0]    interval_cfg,
  input  logic             jitter_en,
  input  logic             done_strobe,
  input  logic             coll_clear,
  output logic             sample_sel,
  output logic             inflight,
  output logic [CNT_W-1:0] coll_count
);
  localparam int CW = IW + 1;

  logic [LFSR_W-1:0] lfsr_st;
  logic [IW-1:0]     base;
  logic [CW-1:0]     reload;
  logic              fresh, expire;

  always_comb begin
    base   = (interval_cfg == '0) ? IW'(MIN_INTERVAL) : interval_cfg;
    reload = {1'b0, base};
    if (jitter_en) reload = reload + CW'(lfsr_st[JIT_W-1:0]);
  end

  sp_lfsr u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .step_i  (fresh),
    .state_o (lfsr_st)
  );

  sp_interval #(.CW(CW)) u_interval (
    .clk        (clk),
    .rst        (rst),
    .op_valid_i (op_valid),
    .reload_i   (reload),
    .fresh_o    (fresh),
    .expire_o   (expire)
  );

  sp_track #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .expire_i   (expire),
    .done_i     (done_strobe),
    .clear_i    (coll_clear),
    .sel_o      (sample_sel),
    .inflight_o (inflight),
    .coll_o     (coll_count)
  );
endmodule

// File: rtl/op_sample_picker_chk.sv
module op_sample_picker_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             done_strobe,
  input logic             coll_clear,
  input logic             sample_sel,
  input logic             inflight,
  input logic [CNT_W-1:0] coll_count
);
  // R5
  sel_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sample_sel |-> inflight);

  // R6
  no_double_track_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inflight) && !$past(done_strobe)) |-> !sample_sel);

  // R5
  busy_clears_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(inflight) && !$past(rst)) |-> $past(done_strobe));

  // R10
  sel_after_op_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_sel && !$past(rst)) |-> $past(op_valid));

  // R8
  coll_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !coll_clear |=> (coll_count >= $past(coll_count)));

  // R6
  coll_step_one_chk: assert property (@(posedge clk) disable iff (rst)
    !coll_clear |=> ((coll_count - $past(coll_count)) <= CNT_W'(1)));

  // R9
  coll_clear_chk: assert property (@(posedge clk) disable iff (rst)
    coll_clear |=> (coll_count == '0));
endmodule

bind op_sample_picker op_sample_picker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .done_strobe (done_strobe),
  .coll_clear  (coll_clear),
  .sample_sel  (sample_sel),
  .inflight    (inflight),
  .coll_count  (coll_count)
);

// File: tb/op_sample_picker_tb_top.sv
module op_sample_picker_tb_top;
  localparam int IW = 16;
  localparam int CNT_W = 4;
  localparam int NROWS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0, jitter_en = 1'b0, done_strobe = 1'b0, coll_clear = 1'b0;
  logic [IW-1:0] interval_cfg = '0;
  logic sample_sel, inflight;
  logic [CNT_W-1:0] coll_count;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  op_sample_picker #(.IW(IW), .JIT_W(8), .MIN_INTERVAL(8), .CNT_W(CNT_W)) dut_i (
    .clk, .rst, .op_valid, .interval_cfg, .jitter_en, .done_strobe,
    .coll_clear, .sample_sel, .inflight, .coll_count
  );

  // rows: interval, jitter, idle gap between ops, expected ops to selection
  localparam logic [15:0] V_CFG [NROWS] = '{16'd5, 16'd1, 16'd0, 16'd3, 16'd20, 16'd4};
  localparam bit          V_JIT [NROWS] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam int          V_GAP [NROWS] = '{0, 0, 0, 2, 1, 0};
  localparam int          V_EXP [NROWS] = '{5, 1, 8, 3, 20, 229}; // 229 = 4 + 8'hE1 (R4)

  function automatic logic [15:0] ref_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic op, input logic done, input logic clr);
    @(negedge clk);
    op_valid = op; done_strobe = done; coll_clear = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 0; done_strobe = 0; coll_clear = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(sample_sel == 0 && inflight == 0 && coll_count == 0, "R1", {sample_sel, inflight, coll_count}, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic count_interval(input int gap, output int n, output int idle_sel);
    bit got = 0;
    n = 0; idle_sel = 0;
    while (!got && n < 400) begin
      step(1, 0, 0);
      n++;
      if (sample_sel) got = 1;
      else for (int g = 0; g < gap; g++) begin
        step(0, 0, 0);
        if (sample_sel) idle_sel++;
      end
    end
  endtask

  initial begin
    int n, idle;
    logic [15:0] lf;
    do_reset();

    for (int r = 0; r < NROWS; r++) begin
      do_reset();
      @(negedge clk);
      interval_cfg = V_CFG[r]; jitter_en = V_JIT[r];
      count_interval(V_GAP[r], n, idle);
      chk(n == V_EXP[r], (r == 2) ? "R3" : (V_JIT[r] ? "R4" : "R2"), n, V_EXP[r]);
      chk(idle == 0, "R2 idle", idle, 0);
      chk(inflight == 1, "R5 set", inflight, 1);
      step(0, 1, 0);
      chk(inflight == 0, "R5 clear", inflight, 0);
    end

    // second jittered interval uses the stepped LFSR (R4)
    do_reset();
    @(negedge clk);
    interval_cfg = 16'd4; jitter_en = 1'b1;
    lf = 16'hACE1;
    count_interval(0, n, idle);
    chk(n == 4 + lf[7:0], "R4 first", n, 4 + lf[7:0]);
    step(0, 1, 0);
    lf = ref_lfsr(lf);
    count_interval(0, n, idle);
    chk(n == 4 + lf[7:0], "R4 second", n, 4 + lf[7:0]);
    step(0, 1, 0);
    step(0, 1, 0);
    chk(inflight == 0 && sample_sel == 0, "R5 idle done ignored", inflight, 0);

    // collisions with interval 2 (R6, R7)
    do_reset();
    @(negedge clk);
    interval_cfg = 16'd2; jitter_en = 1'b0;
    step(1, 0, 0); step(1, 0, 0);
    chk(sample_sel == 1, "R2 interval 2", sample_sel, 1);
    step(1, 0, 0); step(1, 0, 0);
    chk(sample_sel == 0, "R6 dropped", sample_sel, 0);
    chk(coll_count == 1, "R6 count", coll_count, 1);
    step(1, 0, 0);
    chk(sample_sel == 0 && coll_count == 1, "R6 reload full", coll_count, 1);
    step(1, 0, 0);
    chk(coll_count == 2, "R6 count2", coll_count, 2);
    step(1, 0, 0); step(1, 1, 0);
    chk(sample_sel == 1, "R7 sel", sample_sel, 1);
    chk(inflight == 1, "R7 busy", inflight, 1);
    chk(coll_count == 2, "R7 no coll", coll_count, 2);

    // saturation and clear (R8, R9)
    do_reset();
    @(negedge clk);
    interval_cfg = 16'd1;
    step(1, 0, 0);
    chk(sample_sel == 1, "R2 interval 1", sample_sel, 1);
    for (int k = 0; k < 20; k++) step(1, 0, 0);
    chk(coll_count == 4'hF, "R8 saturate", coll_count, 15);
    step(1, 0, 1);
    chk(coll_count == 0, "R9 clear priority", coll_count, 0);
    step(1, 0, 0);
    chk(coll_count == 1, "R9 counts again", coll_count, 1);
    step(0, 0, 1);
    chk(coll_count == 0 && sample_sel == 0, "R9 clear idle", coll_count, 0);
    chk(sample_sel == 0, "R10 no op no sel", sample_sel, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule